// File: doc/BRIEF.md
# SDRAM Control and Self-Refresh Sequencer

This block holds a small software-written control word for an SDRAM port. It turns that word into commands on the chip-select, row-strobe, column-strobe and write-enable pins, and it drives the clock-enable pin. Software runs device bring-up one command at a time. It writes a two-bit code, and each write of a non-zero code produces one SDRAM command. The block also carries a power-down/reset pin that follows a control bit directly.

Self-refresh works through a request bit and a separate acknowledge. The block leaves reset with the device already in self-refresh, so software must clear the request bit before it can run any command. After making a request, software polls the acknowledge to learn the real mode. Outside self-refresh, a policy bit selects between two behaviours. In one, clock-enable is dropped after a run of idle cycles to save power. In the other, clock-enable is held high at all times.

Control word layout, used for both writes and reads:
- bit 0: clock-enable policy.
- bit 1: self-refresh request.
- bits 3:2: init code.
- bit 4: power pin.
- bit 5: self-refresh acknowledge. This bit is read-only.

Command encodings are given as {CS#,RAS#,CAS#,WE#}.

Top module: `sdram_ctl_seq`

## Requirements
- R1: After reset the outputs are as follows: srAck is 1, sdCke is 0, the command is NOP (0111) and pwrPin is 0. rdData reads 0x22 (request bit 1 set, acknowledge bit 5 set).
- R2: In normal mode, writing a non-zero init code to bits 3:2 issues exactly one command. It appears one cycle after the write if sdCke is already high. Code 01 gives mode-register-set (0000), 10 gives precharge-all (0010) and 11 gives NOP (0111). Writing code 00 issues no command.
- R3: sdCke is high whenever a mode-register-set or precharge command is on the bus. If sdCke is low when such a command is pending, it rises one cycle before the command.
- R4: Writing 0 to the request bit while in self-refresh starts the exit. sdCke rises one cycle after the write. The bus then carries only NOPs, and srAck falls EXIT_CYC+2 cycles after the write.
- R5: Writing 1 to the request bit in normal mode, with sdCke high, starts the entry. The next cycle issues precharge-all. The cycle after that issues refresh (0001) with sdCke low. srAck rises on the following cycle.
- R6: Whenever srAck is high, the command on the bus is NOP.
- R7: With bit 0 at 0 and no work pending, sdCke falls on the cycle after devIdle has been sampled high on IDLE_CYC consecutive edges. sdCke rises again one cycle after devIdle goes low.
- R8: With bit 0 at 1, sdCke stays high in normal mode regardless of devIdle.
- R9: pwrPin takes the value of bit 4 on the edge that writes it, and changes at no other time.
- R10: A non-zero init code written during self-refresh is not issued while asleep. It is held, and issued on the cycle after srAck falls.
- R11: rdData returns bits 4:0 as last written and the live acknowledge in bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 8 | Control word write data |
| devIdle | input | 1 | High while the attached devices have no work |
| rdData | output | 8 | Control word and acknowledge readback |
| sdCke | output | 1 | SDRAM clock enable |
| sdCsN | output | 1 | SDRAM chip select, active low |
| sdRasN | output | 1 | SDRAM row strobe, active low |
| sdCasN | output | 1 | SDRAM column strobe, active low |
| sdWeN | output | 1 | SDRAM write enable, active low |
| pwrPin | output | 1 | Power-down/reset pin |
| srAck | output | 1 | Self-refresh acknowledge |

## Verification
The three non-zero init codes are each written with clock-enable already high. This separates the command encodings and confirms that each write produces exactly one command. A write of code 00 confirms that no command is produced. One init write is then made while clock-enable has been dropped by idleness, which distinguishes the wake cycle from the command cycle. Self-refresh is exercised in both directions, and the exit is timed edge by edge so that an off-by-one in the recovery count shows up. An init code written while asleep, followed by an exit, shows that a request made during sleep is held rather than dropped or issued early. The idle run is counted to the exact edge, under both settings of the clock-enable policy bit.

// File: rtl/sdram_ctl_pkg.sv
package sdram_ctl_pkg;

  localparam int REG_W        = 8;
  localparam int BIT_CKE_KEEP = 0;
  localparam int BIT_SR_REQ   = 1;
  localparam int BIT_INIT_LO  = 2;
  localparam int BIT_PWR      = 4;
  localparam int BIT_ACK      = 5;

  // {CS#, RAS#, CAS#, WE#}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdCmd_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ENT_REF,
    ST_ENT_ACK,
    ST_SLEEP,
    ST_EXIT
  } seqState_e;

  typedef struct packed {
    logic issueInit;
    logic issuePre;
    logic issueRef;
    logic ckeUp;
    logic ckeDown;
    logic ackUp;
    logic ackDown;
    logic exitLoad;
  } seqStrobe_t;

  typedef struct packed {
    logic srReq;
    logic ckeKeep;
    logic pendValid;
    logic ckeOn;
    logic idleReached;
    logic exitDone;
  } seqStatus_t;

  function automatic sdCmd_e initToCmd(input logic [1:0] code);
    case (code)
      2'b01:   return CMD_MRS;
      2'b10:   return CMD_PRE;
      default: return CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdram_ctl_dp.sv
module sdram_ctl_dp
  import sdram_ctl_pkg::*;
#(
  parameter int IDLE_CYC = 4,
  parameter int EXIT_CYC = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             devIdle,
  input  seqStrobe_t       strobe,
  output seqStatus_t       status,
  output logic [3:0]       cmdOut,
  output logic             ckeOut,
  output logic             ackOut,
  output logic             pwrOut,
  output logic [REG_W-1:0] rdData
);

  localparam int IDLE_W = $clog2(IDLE_CYC + 1);
  localparam int EXIT_W = $clog2(EXIT_CYC + 1);
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(IDLE_CYC);
  localparam logic [EXIT_W-1:0] EXIT_LIM = EXIT_W'(EXIT_CYC);

  logic              ckeKeepQ;
  logic              srReqQ;
  logic [1:0]        initQ;
  logic              pwrQ;
  logic              pendValidQ;
  logic [1:0]        pendCodeQ;
  logic [IDLE_W-1:0] idleCnt;
  logic [EXIT_W-1:0] exitCnt;
  sdCmd_e            cmdQ;
  logic              ckeQ;
  logic              ackQ;
  logic [1:0]        wrCode;
  logic              unusedHighBits;

  assign wrCode         = wrData[BIT_INIT_LO +: 2];
  assign unusedHighBits = ^wrData[REG_W-1:BIT_ACK];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckeKeepQ   <= 1'b0;
      srReqQ     <= 1'b1;
      initQ      <= 2'b00;
      pwrQ       <= 1'b0;
      pendValidQ <= 1'b0;
      pendCodeQ  <= 2'b00;
      idleCnt    <= '0;
      exitCnt    <= '0;
      cmdQ       <= CMD_NOP;
      ckeQ       <= 1'b0;
      ackQ       <= 1'b1;
    end else begin
      if (wrEn) begin
        ckeKeepQ <= wrData[BIT_CKE_KEEP];
        srReqQ   <= wrData[BIT_SR_REQ];
        initQ    <= wrCode;
        pwrQ     <= wrData[BIT_PWR];
      end

      if (wrEn && wrCode != 2'b00) begin
        pendValidQ <= 1'b1;
        pendCodeQ  <= wrCode;
      end else if (strobe.issueInit) begin
        pendValidQ <= 1'b0;
      end

      if (!devIdle)               idleCnt <= '0;
      else if (idleCnt != IDLE_LIM) idleCnt <= idleCnt + 1'b1;

      if (strobe.exitLoad)        exitCnt <= EXIT_LIM;
      else if (exitCnt != '0)     exitCnt <= exitCnt - 1'b1;

      if (strobe.issueInit)       cmdQ <= initToCmd(pendCodeQ);
      else if (strobe.issuePre)   cmdQ <= CMD_PRE;
      else if (strobe.issueRef)   cmdQ <= CMD_REF;
      else                        cmdQ <= CMD_NOP;

      if (strobe.ckeUp)           ckeQ <= 1'b1;
      else if (strobe.ckeDown)    ckeQ <= 1'b0;

      if (strobe.ackUp)           ackQ <= 1'b1;
      else if (strobe.ackDown)    ackQ <= 1'b0;
    end
  end

  always_comb begin
    status.srReq       = srReqQ;
    status.ckeKeep     = ckeKeepQ;
    status.pendValid   = pendValidQ;
    status.ckeOn       = ckeQ;
    status.idleReached = (idleCnt == IDLE_LIM);
    status.exitDone    = (exitCnt == '0);
  end

  always_comb begin
    rdData                    = '0;
    rdData[BIT_CKE_KEEP]      = ckeKeepQ;
    rdData[BIT_SR_REQ]        = srReqQ;
    rdData[BIT_INIT_LO +: 2]  = initQ;
    rdData[BIT_PWR]           = pwrQ;
    rdData[BIT_ACK]           = ackQ;
  end

  assign cmdOut = cmdQ;
  assign ckeOut = ckeQ;
  assign ackOut = ackQ;
  assign pwrOut = pwrQ;

endmodule

// File: rtl/sdram_ctl_fsm.sv
module sdram_ctl_fsm
  import sdram_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       devIdle,
  input  seqStatus_t status,
  output seqStrobe_t strobe
);

  seqState_e stateQ, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_SLEEP;
    else       stateQ <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = stateQ;
    unique case (stateQ)
      ST_RUN: begin
        if (status.pendValid) begin
          if (status.ckeOn) strobe.issueInit = 1'b1;
          else              strobe.ckeUp     = 1'b1;
        end else if (status.srReq) begin
          if (status.ckeOn) begin
            strobe.issuePre = 1'b1;
            stateNext       = ST_ENT_REF;
          end else begin
            strobe.ckeUp = 1'b1;
          end
        end else if (status.ckeKeep || !devIdle) begin
          if (!status.ckeOn) strobe.ckeUp = 1'b1;
        end else if (status.idleReached && status.ckeOn) begin
          strobe.ckeDown = 1'b1;
        end
      end
      ST_ENT_REF: begin
        strobe.issueRef = 1'b1;
        strobe.ckeDown  = 1'b1;
        stateNext       = ST_ENT_ACK;
      end
      ST_ENT_ACK: begin
        strobe.ackUp = 1'b1;
        stateNext    = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (!status.srReq) begin
          strobe.ckeUp    = 1'b1;
          strobe.exitLoad = 1'b1;
          stateNext       = ST_EXIT;
        end
      end
      ST_EXIT: begin
        if (status.exitDone) begin
          strobe.ackDown = 1'b1;
          stateNext      = ST_RUN;
        end
      end
      default: stateNext = ST_SLEEP;
    endcase
  end

endmodule

// File: rtl/sdram_ctl_seq.sv
module sdram_ctl_seq
  import sdram_ctl_pkg::*;
#(
  parameter int IDLE_CYC = 4,
  parameter int EXIT_CYC = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       devIdle,
  output logic [7:0] rdData,
  output logic       sdCke,
  output logic       sdCsN,
  output logic       sdRasN,
  output logic       sdCasN,
  output logic       sdWeN,
  output logic       pwrPin,
  output logic       srAck
);

  seqStrobe_t strobe;
  seqStatus_t status;
  logic [3:0] cmdBus;

  sdram_ctl_fsm u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .devIdle (devIdle),
    .status  (status),
    .strobe  (strobe)
  );

  sdram_ctl_dp #(
    .IDLE_CYC (IDLE_CYC),
    .EXIT_CYC (EXIT_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .devIdle (devIdle),
    .strobe  (strobe),
    .status  (status),
    .cmdOut  (cmdBus),
    .ckeOut  (sdCke),
    .ackOut  (srAck),
    .pwrOut  (pwrPin),
    .rdData  (rdData)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdBus;

endmodule

// File: rtl/sdram_ctl_chk.sv
module sdram_ctl_chk
  import sdram_ctl_pkg::*;
#(
  parameter int IDLE_CYC = 4
) (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic devIdle,
  input logic sdCke,
  input logic sdCsN,
  input logic sdRasN,
  input logic sdCasN,
  input logic sdWeN,
  input logic pwrPin,
  input logic srAck
);

  logic [3:0] cmd;
  int         idleRun;

  assign cmd = {sdCsN, sdRasN, sdCasN, sdWeN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             idleRun <= 0;
    else if (!devIdle)     idleRun <= 0;
    else if (idleRun < IDLE_CYC) idleRun <= idleRun + 1;
  end

  assert_init_cke_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_MRS || cmd == CMD_PRE) |-> sdCke);

  assert_ref_cke_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_REF) |-> !sdCke);

  assert_ack_after_ref_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srAck) |-> $past(cmd) == CMD_REF);

  assert_ack_quiet_bus_R6: assert property (@(posedge clk) disable iff (!rstN)
    srAck |-> cmd == CMD_NOP);

  assert_exit_cke_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(srAck) |-> (sdCke && $past(sdCke)));

  assert_pwr_only_on_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> $stable(pwrPin));

  assert_idle_run_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdCke) && cmd != CMD_REF) |-> idleRun >= IDLE_CYC);

endmodule

bind sdram_ctl_seq sdram_ctl_chk #(.IDLE_CYC(IDLE_CYC)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .devIdle (devIdle),
  .sdCke   (sdCke),
  .sdCsN   (sdCsN),
  .sdRasN  (sdRasN),
  .sdCasN  (sdCasN),
  .sdWeN   (sdWeN),
  .pwrPin  (pwrPin),
  .srAck   (srAck)
);

// File: tb/sim_sdram_ctl_seq.sv
`timescale 1ns/100ps
module sim_sdram_ctl_seq;

  localparam int IDLE_CYC = 4;
  localparam int EXIT_CYC = 6;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_NOP = 4'b0111;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       devIdle = 1'b0;
  logic [7:0] rdData;
  logic       sdCke, sdCsN, sdRasN, sdCasN, sdWeN, pwrPin, srAck;
  logic [3:0] cmd;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  assign cmd = {sdCsN, sdRasN, sdCasN, sdWeN};

  always #2.5 clk = ~clk;

  sdram_ctl_seq #(.IDLE_CYC(IDLE_CYC), .EXIT_CYC(EXIT_CYC)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .devIdle(devIdle),
    .rdData(rdData), .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .pwrPin(pwrPin), .srAck(srAck)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) step();
    check("R1 ack", srAck, 1);
    check("R1 cke", sdCke, 0);
    check("R1 cmd", cmd, C_NOP);
    check("R1 pwr", pwrPin, 0);
    check("R1 rdData", rdData, 8'h22);
    rstN = 1'b1;
    step();
    check("R1 ack after release", srAck, 1);
  endtask

  task automatic testExit();
    bit busQuiet = 1'b1;
    wrReg(8'h00);
    step();
    check("R4 cke raised", sdCke, 1);
    check("R4 ack held", srAck, 1);
    for (int i = 0; i < EXIT_CYC; i++) begin
      if (cmd !== C_NOP || srAck !== 1'b1) busQuiet = 1'b0;
      step();
    end
    check("R4 nop and ack during recovery", busQuiet, 1);
    check("R4 ack still high at W+7", srAck, 1);
    step();
    check("R4 ack falls at W+8", srAck, 0);
    check("R11 ack bit cleared", rdData, 8'h00);
  endtask

  task automatic testInit();
    logic [3:0] expCmd [3] = '{C_MRS, C_PRE, C_NOP};
    for (int c = 1; c <= 3; c++) begin
      wrReg(8'(c << 2));
      step();
      check("R2 init command", cmd, expCmd[c-1]);
      check("R3 cke during init", sdCke, 1);
      step();
      check("R2 single command", cmd, C_NOP);
    end
    check("R11 readback init field", rdData, 8'h0C);
    wrReg(8'h00);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R2 code 00 no command", cmd, C_NOP);
    end
  endtask

  task automatic testPwr();
    wrReg(8'h10);
    check("R9 pwr high", pwrPin, 1);
    check("R11 readback pwr", rdData, 8'h10);
    step();
    check("R9 pwr holds", pwrPin, 1);
    wrReg(8'h00);
    check("R9 pwr low", pwrPin, 0);
  endtask

  task automatic testIdle();
    bit stayedHigh = 1'b1;
    devIdle = 1'b1;
    for (int i = 0; i < IDLE_CYC; i++) begin
      step();
      if (sdCke !== 1'b1) stayedHigh = 1'b0;
    end
    check("R7 cke held during idle run", stayedHigh, 1);
    step();
    check("R7 cke dropped", sdCke, 0);
    wrReg(8'h04);
    check("R3 cke low before wake", sdCke, 0);
    step();
    check("R3 wake cycle cke", sdCke, 1);
    check("R3 wake cycle nop", cmd, C_NOP);
    step();
    check("R3 mrs after wake", cmd, C_MRS);
    check("R3 cke with mrs", sdCke, 1);
    step();
    check("R7 cke drops again", sdCke, 0);
    devIdle = 1'b0;
    step();
    check("R7 cke rises on activity", sdCke, 1);
  endtask

  task automatic testKeep();
    bit stayedHigh = 1'b1;
    wrReg(8'h01);
    devIdle = 1'b1;
    for (int i = 0; i < 3 * IDLE_CYC; i++) begin
      step();
      if (sdCke !== 1'b1) stayedHigh = 1'b0;
    end
    check("R8 cke kept high", stayedHigh, 1);
  endtask

  task automatic testEntryAndHold();
    bit quiet = 1'b1;
    wrReg(8'h03);
    step();
    check("R5 precharge", cmd, C_PRE);
    check("R5 cke at precharge", sdCke, 1);
    check("R5 ack low at precharge", srAck, 0);
    step();
    check("R5 refresh", cmd, C_REF);
    check("R5 cke low at refresh", sdCke, 0);
    check("R5 ack low at refresh", srAck, 0);
    step();
    check("R5 ack raised", srAck, 1);
    check("R6 nop while asleep", cmd, C_NOP);
    wrReg(8'h0A);
    for (int i = 0; i < 4; i++) begin
      step();
      if (cmd !== C_NOP || sdCke !== 1'b0) quiet = 1'b0;
    end
    check("R10 no command while asleep", quiet, 1);
    check("R11 readback asleep", rdData, 8'h2A);
    devIdle = 1'b0;
    wrReg(8'h00);
    step();
    check("R4 cke raised again", sdCke, 1);
    repeat (EXIT_CYC + 1) step();
    check("R10 ack fallen", srAck, 0);
    check("R10 nothing on ack fall", cmd, C_NOP);
    step();
    check("R10 held command issued", cmd, C_PRE);
  endtask

  initial begin
    testReset();
    testExit();
    testInit();
    testPwr();
    testIdle();
    testKeep();
    testEntryAndHold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule